// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block lets a clocked design use an asynchronous, fully static RAM that is one bit wide, with separate data-in and data-out pins and active-low select, write-enable and output-enable strobes. On its user side it takes one read or write request at a time, made of a 22-bit address and a single write bit. A request is taken in any cycle in which the block is idle. Read results come back with a one-cycle valid strobe, and a busy flag shows when a request is in progress.

Two parameters set the timing. `CLK_PERIOD_NS` gives the clock period and `GRADE` picks the speed grade: 0 is the faster part and 1 is the slower part. From these, each pin phase is given a fixed number of clocks. Each count is the nanosecond minimum for that phase divided by the clock period, rounded up, and never less than one clock.

A write ends on the rising edge of write enable, while chip select is still low. The address and data stay on the pins until chip select has been released, so the hold time is met with a full clock of margin. A read keeps select and output enable low for the whole access time. The output pin is sampled on the last edge of that window.

Top module: `sram_seq_ctl`

## Requirements
- R1: While reset is asserted, and right after it, chip select, write enable and output enable are all high, and busy and read-valid are low.
- R2: After a write request is accepted, chip select goes low and write enable stays high for exactly SU = 1 clock, the address setup phase. A zero setup time is rounded up to one clock.
- R3: Write enable is then low for exactly STB clocks, with chip select low. STB is the largest of the rounded-up counts for the write pulse, the select setup, address-to-write-enable-high and the data setup. The fast grade uses 10, 10, 10 and 6 ns. The slow grade uses 12, 12, 12 and 7 ns.
- R4: After write enable rises, chip select stays low for REC clocks and then goes high. REC is the larger of ceil(1 ns / T) and (ceil(write cycle / T) − SU − STB), where the write cycle is 12 ns on the fast grade and 15 ns on the slow grade. The bit stored in the RAM is the requested write bit.
- R5: Output enable is high during the whole write, and in particular whenever write enable is low.
- R6: The address and data-in pins do not change while chip select is low.
- R7: A read holds chip select and output enable low, with write enable high, for exactly ACC = ceil(access / T) clocks. The access time is 12 ns on the fast grade and 15 ns on the slow grade. The data-out pin is sampled on the clock edge that ends this window.
- R8: In the clock after the read window, read-valid is high for exactly one cycle. Read data shows the sampled bit, and all strobes are high.
- R9: Busy rises in the cycle after a request is accepted. It stays high for SU+STB+REC clocks for a write and ACC+1 clocks for a read. Chip select is high whenever busy is low. A request presented while busy is high is ignored and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 1 | Bit to write |
| busy | output | 1 | A request is in progress |
| rdata | output | 1 | Last bit read |
| rvalid | output | 1 | One-cycle strobe: rdata is new |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_din | output | 1 | RAM data-in pin |
| sram_q | input | 1 | RAM data-out pin |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |

## Verification
With a 5 ns clock on the fast grade, a write holds busy for 1+2+1 = 4 clocks and a read for 3+1 clocks. Read-valid is due in the fourth clock after the accepting edge. The bench samples every output on the falling edge. It counts the select, write-enable and read windows, and checks their lengths when chip select rises. It checks read-valid and read data at exactly the ACC+1-th falling edge after acceptance. The RAM model drives an inverted bit on its data-out pin until ACC falling edges of the read window have passed. As a result, a read window that is even one clock short returns a wrong value.

// File: rtl/sram_seq_ctl_pkg.sv
package sram_seq_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SETUP   = 3'd1,
    PH_STROBE  = 3'd2,
    PH_RECOVER = 3'd3,
    PH_ACCESS  = 3'd4,
    PH_CAPTURE = 3'd5
  } phase_e;

  typedef enum logic [2:0] {
    LIM_ADDR_SETUP,
    LIM_WE_PULSE,
    LIM_CS_SETUP,
    LIM_ADDR_TO_WEH,
    LIM_DATA_SETUP,
    LIM_WR_CYCLE,
    LIM_RECOVERY,
    LIM_ACCESS
  } limit_e;

  // nanosecond minimum per grade (0 = fast, 1 = slow)
  function automatic int unsigned limit_ns(input int unsigned grade, input limit_e which);
    int unsigned v;
    case (which)
      LIM_ADDR_SETUP:  v = 0;
      LIM_WE_PULSE:    v = (grade != 0) ? 12 : 10;
      LIM_CS_SETUP:    v = (grade != 0) ? 12 : 10;
      LIM_ADDR_TO_WEH: v = (grade != 0) ? 12 : 10;
      LIM_DATA_SETUP:  v = (grade != 0) ? 7 : 6;
      LIM_WR_CYCLE:    v = (grade != 0) ? 15 : 12;
      LIM_RECOVERY:    v = 1;
      LIM_ACCESS:      v = (grade != 0) ? 15 : 12;
      default:         v = 0;
    endcase
    return v;
  endfunction

  function automatic int unsigned clocks_for(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned setup_clks(input int unsigned period, input int unsigned grade);
    return clocks_for(limit_ns(grade, LIM_ADDR_SETUP), period);
  endfunction

  function automatic int unsigned strobe_clks(input int unsigned period, input int unsigned grade);
    int unsigned m;
    m = clocks_for(limit_ns(grade, LIM_WE_PULSE), period);
    m = max2(m, clocks_for(limit_ns(grade, LIM_CS_SETUP), period));
    m = max2(m, clocks_for(limit_ns(grade, LIM_ADDR_TO_WEH), period));
    m = max2(m, clocks_for(limit_ns(grade, LIM_DATA_SETUP), period));
    return m;
  endfunction

  function automatic int unsigned recover_clks(input int unsigned period, input int unsigned grade);
    int unsigned used;
    int unsigned cyc;
    int unsigned rest;
    used = setup_clks(period, grade) + strobe_clks(period, grade);
    cyc  = clocks_for(limit_ns(grade, LIM_WR_CYCLE), period);
    rest = (cyc > used) ? (cyc - used) : 0;
    return max2(rest, clocks_for(limit_ns(grade, LIM_RECOVERY), period));
  endfunction

  function automatic int unsigned access_clks(input int unsigned period, input int unsigned grade);
    return clocks_for(limit_ns(grade, LIM_ACCESS), period);
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_ctl_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int SU_C  = 1,
  parameter int STB_C = 2,
  parameter int REC_C = 1,
  parameter int ACC_C = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output phase_e           phase_q,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             busy
);

  localparam logic [CNT_W-1:0] SU_LD  = CNT_W'(SU_C - 1);
  localparam logic [CNT_W-1:0] STB_LD = CNT_W'(STB_C - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_C - 1);
  localparam logic [CNT_W-1:0] ACC_LD = CNT_W'(ACC_C - 1);

  phase_e phase_d;

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          load   = 1'b1;
          if (req_write) begin
            phase_d  = PH_SETUP;
            load_val = SU_LD;
          end else begin
            phase_d  = PH_ACCESS;
            load_val = ACC_LD;
          end
        end
      end
      PH_SETUP: begin
        if (expired) begin
          phase_d  = PH_STROBE;
          load     = 1'b1;
          load_val = STB_LD;
        end
      end
      PH_STROBE: begin
        if (expired) begin
          phase_d  = PH_RECOVER;
          load     = 1'b1;
          load_val = REC_LD;
        end
      end
      PH_RECOVER: begin
        if (expired) phase_d = PH_IDLE;
      end
      PH_ACCESS: begin
        if (expired) begin
          capture = 1'b1;
          phase_d = PH_CAPTURE;
        end
      end
      PH_CAPTURE: phase_d = PH_IDLE;
      default:    phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_ctl_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  phase_e            phase_q,
  input  logic              capture,
  input  logic              sram_q,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_din,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              rdata,
  output logic              rvalid
);

  logic [ADDR_W-1:0] addr_q;
  logic              din_q;
  logic              rdata_q;
  logic              rvalid_q;

  // address and data are loaded only when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      din_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      din_q  <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 1'b0;
    end else if (capture) begin
      rdata_q <= sram_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
    end
  end

  // strobe levels decoded from the phase register
  always_comb begin
    sram_cs_n = 1'b1;
    sram_we_n = 1'b1;
    sram_oe_n = 1'b1;
    case (phase_q)
      PH_SETUP, PH_RECOVER: sram_cs_n = 1'b0;
      PH_STROBE: begin
        sram_cs_n = 1'b0;
        sram_we_n = 1'b0;
      end
      PH_ACCESS: begin
        sram_cs_n = 1'b0;
        sram_oe_n = 1'b0;
      end
      default: begin
        sram_cs_n = 1'b1;
      end
    endcase
  end

  assign sram_addr = addr_q;
  assign sram_din  = din_q;
  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;

endmodule

// File: rtl/sram_seq_ctl.sv
module sram_seq_ctl
  import sram_seq_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int GRADE         = 0,
  parameter int ADDR_W        = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              busy,
  output logic              rdata,
  output logic              rvalid,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_din,
  input  logic              sram_q,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);

  localparam int SU_C  = int'(setup_clks(CLK_PERIOD_NS, GRADE));
  localparam int STB_C = int'(strobe_clks(CLK_PERIOD_NS, GRADE));
  localparam int REC_C = int'(recover_clks(CLK_PERIOD_NS, GRADE));
  localparam int ACC_C = int'(access_clks(CLK_PERIOD_NS, GRADE));
  localparam int MAX_C = int'(max2(max2(SU_C, STB_C), max2(REC_C, ACC_C)));
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic             rst_meta_n;
  logic             rst_core_n;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;
  logic             accept;
  logic             capture;
  phase_e           phase_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_core_n <= rst_meta_n;
    end
  end

  sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  sram_seq_fsm #(
    .CNT_W (CNT_W),
    .SU_C  (SU_C),
    .STB_C (STB_C),
    .REC_C (REC_C),
    .ACC_C (ACC_C)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .expired   (expired),
    .phase_q   (phase_q),
    .load      (load),
    .load_val  (load_val),
    .accept    (accept),
    .capture   (capture),
    .busy      (busy)
  );

  sram_seq_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .phase_q   (phase_q),
    .capture   (capture),
    .sram_q    (sram_q),
    .sram_addr (sram_addr),
    .sram_din  (sram_din),
    .sram_cs_n (sram_cs_n),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n),
    .rdata     (rdata),
    .rvalid    (rvalid)
  );

endmodule

// File: rtl/sram_seq_ctl_chk.sv
module sram_seq_ctl_chk
  import sram_seq_ctl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 5,
  parameter int GRADE         = 0,
  parameter int ADDR_W        = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rvalid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_din,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_oe_n
);

  localparam int STB_C = int'(strobe_clks(CLK_PERIOD_NS, GRADE));

  logic [15:0] we_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
    end else if (!sram_we_n) begin
      we_run <= we_run + 16'd1;
    end else begin
      we_run <= '0;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> sram_cs_n && sram_we_n && sram_oe_n);

  // R2
  select_before_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(!sram_cs_n));

  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_run == 16'(STB_C)));

  // R3
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_cs_n);

  // R5
  oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_oe_n);

  // R6
  pins_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> ($stable(sram_addr) && $stable(sram_din)));

  // R7
  read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (sram_we_n && !sram_cs_n));

  // R8
  rvalid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

  // R8
  rvalid_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (sram_cs_n && sram_oe_n));

  // R9
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sram_cs_n);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

endmodule

bind sram_seq_ctl sram_seq_ctl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .GRADE         (GRADE),
  .ADDR_W        (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .busy      (busy),
  .rvalid    (rvalid),
  .sram_addr (sram_addr),
  .sram_din  (sram_din),
  .sram_cs_n (sram_cs_n),
  .sram_we_n (sram_we_n),
  .sram_oe_n (sram_oe_n)
);

// File: tb/test_sram_seq_ctl.sv
module test_sram_seq_ctl;

  localparam int CLK_NS = 5;
  localparam int GRADE  = 0;
  localparam int AW     = 22;

  function automatic int ceil_clk(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_SU  = ceil_clk(0);
  localparam int E_STB = imax(imax(ceil_clk(GRADE ? 12 : 10), ceil_clk(GRADE ? 12 : 10)),
                              imax(ceil_clk(GRADE ? 12 : 10), ceil_clk(GRADE ? 7 : 6)));
  localparam int E_REC = imax(ceil_clk(1), ceil_clk(GRADE ? 15 : 12) - E_SU - E_STB);
  localparam int E_ACC = ceil_clk(GRADE ? 15 : 12);

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic          req_wdata;
  logic          busy;
  logic          rdata;
  logic          rvalid;
  logic [AW-1:0] sram_addr;
  logic          sram_din;
  logic          sram_q;
  logic          sram_cs_n;
  logic          sram_we_n;
  logic          sram_oe_n;

  int checks;
  int errors;
  bit mon_on;

  bit ref_mem   [int];
  bit model_mem [int];

  sram_seq_ctl #(.CLK_PERIOD_NS(CLK_NS), .GRADE(GRADE), .ADDR_W(AW)) i_sram_seq_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .busy      (busy),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .sram_addr (sram_addr),
    .sram_din  (sram_din),
    .sram_q    (sram_q),
    .sram_cs_n (sram_cs_n),
    .sram_we_n (sram_we_n),
    .sram_oe_n (sram_oe_n)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2.0) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 1'b0;
  endfunction

  function automatic bit model_rd(input int a);
    return model_mem.exists(a) ? model_mem[a] : 1'b0;
  endfunction

  // RAM model: the write lands on the edge that ends the select/write overlap
  always @(posedge sram_we_n) if (sram_cs_n === 1'b0) model_mem[int'(sram_addr)] = sram_din;
  always @(posedge sram_cs_n) if (sram_we_n === 1'b0) model_mem[int'(sram_addr)] = sram_din;

  // pin-window monitor and read-data model, at falling edges
  int su_n, st_n, rc_n, rd_n;
  bit oe_ok, stable_ok, prev_cs_low;
  logic [AW-1:0] prev_addr;
  logic prev_din;

  initial begin
    sram_q = 1'b0;
    su_n = 0; st_n = 0; rc_n = 0; rd_n = 0;
    oe_ok = 1'b1; stable_ok = 1'b1; prev_cs_low = 1'b0;
    prev_addr = '0; prev_din = 1'b0;
  end

  always @(negedge clk) begin
    if (mon_on) begin
      if (!sram_cs_n) begin
        if (prev_cs_low && (sram_addr != prev_addr || sram_din != prev_din)) stable_ok = 1'b0;
        if (!sram_we_n) begin
          st_n++;
          if (!sram_oe_n) oe_ok = 1'b0;
        end else if (!sram_oe_n) begin
          rd_n++;
        end else if (st_n == 0) begin
          su_n++;
          if (!sram_oe_n) oe_ok = 1'b0;
        end else begin
          rc_n++;
          if (!sram_oe_n) oe_ok = 1'b0;
        end
      end else if (prev_cs_low) begin
        chk("R6", "addr/din steady while selected", int'(stable_ok), 1);
        if (st_n > 0) begin
          chk("R2", "setup clocks", su_n, E_SU);
          chk("R3", "write-enable low clocks", st_n, E_STB);
          chk("R4", "recovery clocks", rc_n, E_REC);
          chk("R5", "output enable high in write", int'(oe_ok), 1);
        end else begin
          chk("R7", "read window clocks", rd_n, E_ACC);
        end
        su_n = 0; st_n = 0; rc_n = 0; rd_n = 0;
        oe_ok = 1'b1; stable_ok = 1'b1;
      end
      prev_cs_low = !sram_cs_n;
      prev_addr   = sram_addr;
      prev_din    = sram_din;
    end
    // data is wrong until the access time has passed
    if (!sram_cs_n && !sram_oe_n && sram_we_n)
      sram_q = (rd_n >= E_ACC) ? model_rd(int'(sram_addr)) : ~model_rd(int'(sram_addr));
    else
      sram_q = 1'b0;
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a, input bit d);
    while (busy) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input bit d, input bit intrude);
    int n;
    issue(1'b1, a, d);
    ref_mem[int'(a)] = d;
    n = 0;
    if (intrude) begin
      // R9: this request arrives while busy and must be dropped
      req_valid = 1'b1; req_write = 1'b1; req_addr = a + 1'b1; req_wdata = ~ref_rd(int'(a + 1'b1));
      if (busy) n++;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R9", "write busy clocks", n, E_SU + E_STB + E_REC);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    bit pre_ok;
    bit exp;
    exp = ref_rd(int'(a));
    issue(1'b0, a, 1'b0);
    pre_ok = 1'b1;
    for (int k = 1; k <= E_ACC; k++) begin
      if (!busy || rvalid) pre_ok = 1'b0;
      @(negedge clk);
    end
    chk("R9", "busy and no valid during read window", int'(pre_ok), 1);
    chk("R8", "rvalid after read window", int'(rvalid), 1);
    chk("R8", "rdata matches stored bit", int'(rdata), int'(exp));
    chk("R8", "strobes idle with rvalid", int'(sram_cs_n && sram_oe_n && sram_we_n), 1);
    chk("R9", "busy in capture clock", int'(busy), 1);
    @(negedge clk);
    chk("R8", "rvalid single cycle", int'(rvalid), 0);
    chk("R9", "busy drops after read", int'(busy), 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=running expected=done");
    finish_run();
  end

  logic [AW-1:0] pool [16];

  initial begin
    checks = 0;
    errors = 0;
    mon_on = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = 1'b0;
    rst_n = 1'b0;
    void'($urandom(32'd4417));
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "cs_n in reset", int'(sram_cs_n), 1);
    chk("R1", "we_n in reset", int'(sram_we_n), 1);
    chk("R1", "oe_n in reset", int'(sram_oe_n), 1);
    chk("R1", "busy/rvalid in reset", int'(busy || rvalid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle after release", int'(sram_cs_n && !busy), 1);
    mon_on = 1'b1;

    // directed corners: lowest and highest address, overwrite
    do_write('0, 1'b1, 1'b0);
    do_write({AW{1'b1}}, 1'b1, 1'b0);
    do_read('0);
    do_read({AW{1'b1}});
    do_write('0, 1'b0, 1'b0);
    do_read('0);
    do_read(22'd12345);
    // R9: request during busy is dropped
    do_write(22'd40, 1'b0, 1'b0);
    do_write(22'd41, 1'b0, 1'b0);
    do_write(22'd40, 1'b1, 1'b1);
    do_read(22'd41);
    do_read(22'd40);
    // R4: the RAM holds what was written
    chk("R4", "stored bit at addr 40", int'(model_rd(40)), 1);

    for (int i = 0; i < 16; i++) pool[i] = AW'($urandom);
    pool[0] = '0;
    pool[1] = {AW{1'b1}};
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = pool[$urandom % 16];
      if ($urandom % 2) do_write(a, 1'($urandom), 1'b0);
      else do_read(a);
    end
    for (int i = 0; i < 16; i++) begin
      chk("R4", "RAM contents match requests", int'(model_rd(int'(pool[i]))), int'(ref_rd(int'(pool[i]))));
    end
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule